// File: doc/BRIEF.md
# Link Test Pattern Generator

This block produces deterministic test words for a serial transmit link so that the far end can check the link without live converter data. A 3-bit mode picks one of seven patterns or switches the generator off: a checkerboard, an all-ones/all-zeros toggle, a long and a short pseudo-random sequence, four user words either looped or sent once, and a ramp. A 2-bit injection select sends the pattern either to the 16-bit sample input of the link or to the 10-bit code input of the physical layer, which sits after the line encoder.

The pattern advances once for each cycle in which the clock enable is high. Each output word is registered and appears one clock after the enabling edge, together with its valid flag. Changing the mode restarts every pattern source. A done flag shows that a single-shot user sequence has finished.

Top module: `ltpg_top`

## Requirements
- R1: After reset both data outputs are zero, both valid flags are low and the done flag is low.
- R2: With mode 000 neither valid flag is ever set and both data outputs read zero.
- R3: Mode 001 gives 0xAAAA on the first word after a restart, then 0x5555, and keeps alternating.
- R4: Mode 010 gives 0xFFFF on the first word, then 0x0000, and keeps alternating.
- R5: Mode 011 gives the low 16 bits of a 23-bit LFSR with feedback bit22 XOR bit17 shifted in at bit 0. The first word is the all-ones seed and the register steps once per word.
- R6: Mode 100 works the same way with a 9-bit LFSR, feedback bit8 XOR bit4. Its 9 bits are zero-extended to 16, so the first word is 0x01FF.
- R7: Mode 101 sends user words 1, 2, 3, 4, one per word, and then starts over at word 1 without end.
- R8: Mode 110 sends user words 1 to 4 once and then only zeros. The done flag goes high together with the output of user word 4 and stays high until the next restart.
- R9: Mode 111 gives 0, 1, 2, … from a restart, adding one per word and wrapping from 0xFFFF to 0x0000.
- R10: Injection select 00 drives the sample output, and 01 drives the code output. For modes 101 and 110 the code word is bits 15:6 of the pattern word; for all other modes it is bits 9:0. With select 10 or 11 neither output is valid. An output whose valid flag is low reads zero.
- R11: A cycle in which the mode differs from the previous cycle's mode is a restart. It gives no valid word, reseeds both LFSRs, returns the user index and ramp to their first values, and clears done.
- R12: While the clock enable is low no valid word is produced and the pattern does not advance.
- R13: A word enabled at a clock edge is present on the outputs, with its valid flag, from that edge until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Advance enable, one word per high cycle |
| mode | input | 3 | Pattern select |
| inj_sel | input | 2 | Injection point select |
| user_pat1 | input | 16 | User word 1 |
| user_pat2 | input | 16 | User word 2 |
| user_pat3 | input | 16 | User word 3 |
| user_pat4 | input | 16 | User word 4 |
| smp_data | output | 16 | Word for the sample input |
| smp_valid | output | 1 | smp_data holds a pattern word |
| code_data | output | 10 | Word for the encoder output |
| code_valid | output | 1 | code_data holds a pattern word |
| single_done | output | 1 | Single-shot user sequence finished |

## Verification
A mode change takes effect at the first clock edge after it. That edge is the restart, and it produces no word. Each later enabled edge puts exactly one word on the outputs, so word k of a pattern can be read half a period after the (k+1)-th enabled edge after the restart. The bench drives its inputs and samples its outputs on falling edges and keeps its own LFSR, ramp and index models in step with these edges. The done flag is compared in the same sample as the word it goes with.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;
  typedef enum logic [2:0] {
    MODE_OFF       = 3'd0,
    MODE_CHECKER   = 3'd1,
    MODE_TOGGLE    = 3'd2,
    MODE_PN_LONG   = 3'd3,
    MODE_PN_SHORT  = 3'd4,
    MODE_USER_LOOP = 3'd5,
    MODE_USER_ONCE = 3'd6,
    MODE_RAMP      = 3'd7
  } tp_mode_e;

  localparam logic [1:0] INJ_SAMPLE = 2'b00;
  localparam logic [1:0] INJ_CODE   = 2'b01;
  localparam int         USER_WORDS = 4;
endpackage

// File: rtl/ltpg_lfsr.sv
module ltpg_lfsr #(
  parameter int LEN   = 23,
  parameter int TAP_B = 17,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reseed,
  input  logic             step,
  output logic [OUT_W-1:0] word
);
  logic [LEN-1:0] state;
  logic           fb;

  assign fb = state[LEN-1] ^ state[TAP_B];

  always_ff @(posedge clk) begin
    if (rst || reseed) state <= '1;
    else if (step)     state <= {state[LEN-2:0], fb};
  end

  generate
    if (LEN >= OUT_W) begin : g_trunc
      assign word = state[OUT_W-1:0];
    end else begin : g_ext
      assign word = {{(OUT_W-LEN){1'b0}}, state};
    end
  endgenerate

  // R5 R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R11
  lfsr_reseed_chk: assert property (@(posedge clk) disable iff (rst)
    reseed |=> state == '1);
endmodule

// File: rtl/ltpg_seq.sv
module ltpg_seq
  import ltpg_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                adv,
  input  tp_mode_e            mode,
  output logic [SAMPLE_W-1:0] step,
  output logic                done
);
  localparam logic [SAMPLE_W-1:0] ONE  = SAMPLE_W'(1);
  localparam logic [SAMPLE_W-1:0] LAST = SAMPLE_W'(USER_WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      step <= '0;
      done <= 1'b0;
    end else if (adv) begin
      step <= step + ONE;
      if (mode == MODE_USER_ONCE && step == LAST) done <= 1'b1;
    end
  end

  // R9
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !restart) |=> step == $past(step) + ONE);

  // R12
  hold_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !restart) |=> $stable(step));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !restart) |=> done);

  // R11
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!done && step == '0));
endmodule

// File: rtl/ltpg_out.sv
module ltpg_out
  import ltpg_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 fire,
  input  tp_mode_e                             mode,
  input  logic [1:0]                           inj_sel,
  input  logic [SAMPLE_W-1:0]                  step,
  input  logic                                 done,
  input  logic [SAMPLE_W-1:0]                  pn_long,
  input  logic [SAMPLE_W-1:0]                  pn_short,
  input  logic [USER_WORDS-1:0][SAMPLE_W-1:0]  user_pat,
  output logic [SAMPLE_W-1:0]                  smp_data,
  output logic                                 smp_valid,
  output logic [CODE_W-1:0]                    code_data,
  output logic                                 code_valid
);
  localparam int IDX_W = $clog2(USER_WORDS);
  localparam logic [SAMPLE_W-1:0] CHK_A = SAMPLE_W'({(SAMPLE_W+1)/2{2'b10}});

  logic [SAMPLE_W-1:0] word;
  logic [CODE_W-1:0]   cword;
  logic                is_user, take_s, take_c;

  always_comb begin
    case (mode)
      MODE_CHECKER:   word = step[0] ? ~CHK_A : CHK_A;
      MODE_TOGGLE:    word = step[0] ? '0 : '1;
      MODE_PN_LONG:   word = pn_long;
      MODE_PN_SHORT:  word = pn_short;
      MODE_USER_LOOP: word = user_pat[step[IDX_W-1:0]];
      MODE_USER_ONCE: word = done ? '0 : user_pat[step[IDX_W-1:0]];
      MODE_RAMP:      word = step;
      default:        word = '0;
    endcase
  end

  assign is_user = (mode == MODE_USER_LOOP) || (mode == MODE_USER_ONCE);
  assign cword   = is_user ? word[SAMPLE_W-1 -: CODE_W] : word[CODE_W-1:0];
  assign take_s  = fire && (mode != MODE_OFF) && (inj_sel == INJ_SAMPLE);
  assign take_c  = fire && (mode != MODE_OFF) && (inj_sel == INJ_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_data   <= '0;
      smp_valid  <= 1'b0;
      code_data  <= '0;
      code_valid <= 1'b0;
    end else begin
      smp_valid  <= take_s;
      code_valid <= take_c;
      smp_data   <= take_s ? word  : '0;
      code_data  <= take_c ? cword : '0;
    end
  end

  // R10
  valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && code_valid));

  // R2
  off_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> (!smp_valid && !code_valid));

  // R12
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> (!smp_valid && !code_valid));

  // R13
  smp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && mode != MODE_OFF && inj_sel == INJ_SAMPLE) |=> smp_valid);
endmodule

// File: rtl/ltpg_top.sv
module ltpg_top
  import ltpg_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 10,
  parameter int PNL_LEN  = 23,
  parameter int PNL_TAP  = 17,
  parameter int PNS_LEN  = 9,
  parameter int PNS_TAP  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_en,
  input  logic [2:0]          mode,
  input  logic [1:0]          inj_sel,
  input  logic [SAMPLE_W-1:0] user_pat1,
  input  logic [SAMPLE_W-1:0] user_pat2,
  input  logic [SAMPLE_W-1:0] user_pat3,
  input  logic [SAMPLE_W-1:0] user_pat4,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_valid,
  output logic [CODE_W-1:0]   code_data,
  output logic                code_valid,
  output logic                single_done
);
  tp_mode_e                             mode_e, mode_q;
  logic                                 restart, adv;
  logic [SAMPLE_W-1:0]                  step, pn_long, pn_short;
  logic [USER_WORDS-1:0][SAMPLE_W-1:0]  user_pat;

  assign mode_e   = tp_mode_e'(mode);
  assign restart  = (mode_e != mode_q);
  assign adv      = clk_en && !restart;
  assign user_pat = {user_pat4, user_pat3, user_pat2, user_pat1};

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_OFF;
    else     mode_q <= mode_e;
  end

  ltpg_lfsr #(.LEN(PNL_LEN), .TAP_B(PNL_TAP), .OUT_W(SAMPLE_W)) u_pn_long (
    .clk(clk), .rst(rst), .reseed(restart), .step(adv), .word(pn_long));

  ltpg_lfsr #(.LEN(PNS_LEN), .TAP_B(PNS_TAP), .OUT_W(SAMPLE_W)) u_pn_short (
    .clk(clk), .rst(rst), .reseed(restart), .step(adv), .word(pn_short));

  ltpg_seq #(.SAMPLE_W(SAMPLE_W)) u_seq (
    .clk(clk), .rst(rst), .restart(restart), .adv(adv), .mode(mode_e),
    .step(step), .done(single_done));

  ltpg_out #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .fire(adv), .mode(mode_e), .inj_sel(inj_sel),
    .step(step), .done(single_done), .pn_long(pn_long), .pn_short(pn_short),
    .user_pat(user_pat), .smp_data(smp_data), .smp_valid(smp_valid),
    .code_data(code_data), .code_valid(code_valid));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!smp_valid && !code_valid && !single_done && smp_data == '0));

  // R11
  restart_silent_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!smp_valid && !code_valid && !single_done));
endmodule

// File: tb/ltpg_top_tb_top.sv
module ltpg_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst, clk_en;
  logic [2:0]  mode;
  logic [1:0]  inj_sel;
  logic [15:0] up1, up2, up3, up4;
  logic [15:0] smp_data;
  logic        smp_valid, code_valid, single_done;
  logic [9:0]  code_data;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  logic [22:0] m23;
  logic [8:0]  m9;

  always #(CLK_PERIOD/2) clk = ~clk;

  ltpg_top dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .mode(mode), .inj_sel(inj_sel),
    .user_pat1(up1), .user_pat2(up2), .user_pat3(up3), .user_pat4(up4),
    .smp_data(smp_data), .smp_valid(smp_valid), .code_data(code_data),
    .code_valid(code_valid), .single_done(single_done));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (time %0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] user_w(input int i);
    case (i % 4)
      0: return up1;
      1: return up2;
      2: return up3;
      default: return up4;
    endcase
  endfunction

  function automatic logic [15:0] exp_word(input logic [2:0] m, input int k);
    case (m)
      3'd1: return (k % 2 == 0) ? 16'hAAAA : 16'h5555;
      3'd2: return (k % 2 == 0) ? 16'hFFFF : 16'h0000;
      3'd3: return m23[15:0];
      3'd4: return {7'd0, m9};
      3'd5: return user_w(k);
      3'd6: return (k < 4) ? user_w(k) : 16'h0000;
      3'd7: return 16'(k);
      default: return 16'h0000;
    endcase
  endfunction

  // restart into mode m (optionally via mode 000), then enable n words
  task automatic run_pattern(input string req, input logic [2:0] m, input logic [1:0] inj,
                             input int n, input int from, input bit via_off);
    logic [15:0] w;
    logic [9:0]  cw;
    bit          sv, cv;
    @(negedge clk);
    clk_en  = 1'b0;
    inj_sel = inj;
    if (via_off) begin
      mode = 3'd0;
      @(negedge clk);
    end
    mode = m;
    @(negedge clk);              // restart edge has passed
    check({req, " R11 restart no word"}, {30'd0, smp_valid, code_valid}, 32'd0);
    m23 = '1;
    m9  = '1;
    clk_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k >= from) begin
        w  = exp_word(m, k);
        cw = (m == 3'd5 || m == 3'd6) ? w[15:6] : w[9:0];
        sv = (m != 3'd0) && (inj == 2'b00);
        cv = (m != 3'd0) && (inj == 2'b01);
        check({req, " R13 smp_valid"}, {31'd0, smp_valid}, {31'd0, sv});
        check({req, " R10 code_valid"}, {31'd0, code_valid}, {31'd0, cv});
        check({req, " smp_data"}, {16'd0, smp_data}, {16'd0, sv ? w : 16'd0});
        check({req, " R10 code_data"}, {22'd0, code_data}, {22'd0, cv ? cw : 10'd0});
        check({req, " R8 done"}, {31'd0, single_done}, {31'd0, (m == 3'd6 && k >= 3)});
      end
      m23 = {m23[21:0], m23[22] ^ m23[17]};
      m9  = {m9[7:0], m9[8] ^ m9[4]};
    end
    clk_en = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 smp_data", {16'd0, smp_data}, 32'd0);
    check("R1 code_data", {22'd0, code_data}, 32'd0);
    check("R1 valids", {30'd0, smp_valid, code_valid}, 32'd0);
    check("R1 done", {31'd0, single_done}, 32'd0);
  endtask

  task automatic test_off();
    run_pattern("R2 off sample", 3'd0, 2'b00, 4, 0, 1'b0);
    run_pattern("R2 off code", 3'd0, 2'b01, 4, 0, 1'b1);
  endtask

  task automatic test_patterns();
    run_pattern("R3 checker", 3'd1, 2'b00, 6, 0, 1'b1);
    run_pattern("R3 checker code", 3'd1, 2'b01, 4, 0, 1'b1);
    run_pattern("R4 toggle", 3'd2, 2'b00, 6, 0, 1'b1);
    run_pattern("R5 pn long", 3'd3, 2'b00, 40, 0, 1'b1);
    run_pattern("R6 pn short", 3'd4, 2'b00, 40, 0, 1'b1);
    run_pattern("R6 pn short code", 3'd4, 2'b01, 20, 0, 1'b1);
    run_pattern("R7 user loop", 3'd5, 2'b00, 11, 0, 1'b1);
    run_pattern("R7 user loop code", 3'd5, 2'b01, 9, 0, 1'b1);
    run_pattern("R8 user once", 3'd6, 2'b00, 9, 0, 1'b1);
    run_pattern("R8 user once code", 3'd6, 2'b01, 7, 0, 1'b1);
    run_pattern("R9 ramp", 3'd7, 2'b00, 8, 0, 1'b1);
  endtask

  task automatic test_wrap();
    run_pattern("R9 ramp code wrap", 3'd7, 2'b01, 1030, 1020, 1'b1);
    run_pattern("R9 ramp sample wrap", 3'd7, 2'b00, 65539, 65533, 1'b1);
  endtask

  task automatic test_reserved();
    run_pattern("R10 reserved 10", 3'd7, 2'b10, 4, 0, 1'b1);
    run_pattern("R10 reserved 11", 3'd1, 2'b11, 4, 0, 1'b1);
  endtask

  task automatic test_restart();
    run_pattern("R11 pn long first", 3'd3, 2'b00, 5, 0, 1'b1);
    run_pattern("R11 pn short direct", 3'd4, 2'b00, 5, 0, 1'b0);
    run_pattern("R11 pn long reseed", 3'd3, 2'b00, 5, 0, 1'b0);
    run_pattern("R11 once before", 3'd6, 2'b00, 6, 0, 1'b0);
    run_pattern("R11 loop after done", 3'd5, 2'b00, 5, 0, 1'b0);
    run_pattern("R11 ramp after loop", 3'd7, 2'b00, 3, 0, 1'b0);
  endtask

  task automatic test_hold();
    run_pattern("R12 ramp start", 3'd7, 2'b00, 2, 0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R12 idle valid", {30'd0, smp_valid, code_valid}, 32'd0);
      check("R12 idle data", {16'd0, smp_data}, 32'd0);
    end
    clk_en = 1'b1;
    @(negedge clk);
    check("R12 resumes at 2", {16'd0, smp_data}, 32'd2);
    check("R13 valid after enable", {31'd0, smp_valid}, 32'd1);
    clk_en = 1'b0;
    @(negedge clk);
    check("R13 valid drops", {31'd0, smp_valid}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; clk_en = 1'b0; mode = 3'd0; inj_sel = 2'b00;
    up1 = 16'h1234; up2 = 16'hFEDC; up3 = 16'h0FC0; up4 = 16'h8001;
    m23 = '1; m9 = '1;
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    test_off();
    test_patterns();
    test_reserved();
    test_restart();
    test_hold();
    test_wrap();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule